// File: doc/BRIEF.md
# Single-Bank DRAM Read Sequencer

This block turns read requests into the strobe and address traffic of one DRAM bank. A request arrives on a valid/ready handshake and carries a row and a column. The block sends the row and then the column over one shared address bus. Three active-low strobes mark each transfer as a row opening, a column read, a precharge or a refresh. When the read data comes back from the device, the block registers it and presents it as a response.

The bank is run with an open-row policy. After a row has been opened, later reads to that same row need only a column command, and the block can issue one of these every clock. A read to a different row must first close the open row. The close is held back until the row has been open for its minimum active time, and the next row can open only after the precharge recovery time has passed. A refresh timer, sized from the retention window and the clock rate, forces a periodic refresh. When it is due, the block closes the open row, refreshes, and then resumes the stalled request.

All timing values are parameters. The defaults are CAS latency 2, row-to-column delay 3, precharge recovery 2, minimum row active time 8 and refresh recovery 6 cycles, with a 100 MHz clock, a 64 ms window and 8192 rows (a refresh every 781 cycles).

Top module: `dram_rd_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every strobe is high, the address bus is zero, `req_ready_o` is low and `rsp_valid_o` is low.
- R2: Command encoding on {ras_n, cas_n, we_n}: idle 111, activate 011 (the address bus carries the row), read 101 (the address bus carries the column, zero-extended), precharge 010, refresh 001. No other code ever appears.
- R3: A read is never issued earlier than T_RCD cycles after the activate that opened its row. On an idle bank, the read follows the activate exactly T_RCD cycles later.
- R4: For a read issued in cycle c, the block samples `dram_dq_i` at the end of cycle c+T_CL and raises `rsp_valid_o` for one cycle in cycle c+T_CL+1 with that value. Responses come back in issue order.
- R5: A precharge is never issued earlier than T_RAS cycles after the last activate. A row miss that arrives early gets its precharge exactly T_RAS cycles after the activate.
- R6: Neither an activate nor a refresh is issued earlier than T_RP cycles after a precharge. When one is already pending, it is issued exactly T_RP cycles after the precharge.
- R7: Reads to the currently open row issue no new activate, and a held request stream gets one read per cycle.
- R8: A request to a different row closes the open row with a precharge and then activates the requested row.
- R9: A refresh comes due every REF_INTERVAL cycles. It closes any open row, is issued only with the bank closed, and holds `req_ready_o` low from the moment it is due until its recovery is over. No activate follows a refresh in less than T_RFC cycles, and a waiting request is activated exactly T_RFC cycles after the refresh.
- R10: A handshake (`req_valid_i` and `req_ready_o` high at a clock edge) puts the read with that request's column on the pins in the next cycle. `req_ready_o` is high only while the requested row is open and the bank is ready for a read.
- R11: A read is issued only while a row is open, and an activate only while no row is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_ready_o | output | 1 | Request accepted at this edge if valid |
| req_row_i | input | ROW_W | Row of the request |
| req_col_i | input | COL_W | Column of the request |
| dram_addr_o | output | ADDR_W | Shared row/column address bus |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write-enable strobe, active low |
| dram_dq_i | input | DATA_W | Read data from the device |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_data_o | output | DATA_W | Read response data |

## Verification
Corrupted timer or bank state shows up on the strobes within a single command. A read, precharge, activate or refresh that comes a cycle too early breaks a spacing rule as soon as it reaches the pins. A stale open-row record produces either a read without a prior activate or a read whose data belongs to the wrong row, and that wrong data appears T_CL+1 cycles later. A read pipeline that is off by a stage makes a response one cycle early or late, or lets it capture the idle pattern of the data bus. A refresh timer fault either produces no refresh near cycle 781 or lets `req_ready_o` stay high while the bank is closed.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    // The encoding is {ras_n, cas_n, we_n}, so a command value drives the pins as it is.
    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_ACT = 3'b011,
        CMD_RD  = 3'b101,
        CMD_PRE = 3'b010,
        CMD_REF = 3'b001
    } dram_cmd_e;

    typedef enum logic {
        BANK_CLOSED = 1'b0,
        BANK_OPEN   = 1'b1
    } bank_st_e;

endpackage

// File: rtl/seq_gap_timer.sv
// Down-counter that is loaded with (T-1) when a command issues. It reports done
// in the cycle in which the dependent command may be decided, so that command
// reaches the pins T cycles after the first one.
module seq_gap_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         done_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

    // R3: a nonzero load blocks the dependent command in the following cycle
    assert_gap_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && val_i != '0) |=> !done_o);
endmodule

// File: rtl/seq_ref_timer.sv
// Free-running refresh interval counter. It raises pend_o when the interval
// wraps and holds it until the refresh is issued.
module seq_ref_timer #(
    parameter int INTERVAL = 781
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ack_i,
    output logic pend_o
);
    localparam int CW = $clog2(INTERVAL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } ref_state_t;

    ref_state_t cur_q, nxt_d;
    logic       wrap;

    always_comb begin
        nxt_d = cur_q;
        wrap  = (cur_q.cnt == CW'(INTERVAL - 1));
        nxt_d.cnt = wrap ? '0 : cur_q.cnt + 1'b1;
        if (wrap)       nxt_d.pend = 1'b1;
        else if (ack_i) nxt_d.pend = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign pend_o = cur_q.pend;

    // R9: a due refresh is never dropped before it is served
    assert_ref_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && !ack_i) |=> pend_o);
endmodule

// File: rtl/seq_read_pipe.sv
// Tracks issued reads through CAS latency and captures the data bus when each
// read's data is due.
module seq_read_pipe #(
    parameter int CL = 2,
    parameter int DW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          issue_i,
    input  logic [DW-1:0] dq_i,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_data_o
);
    typedef struct packed {
        logic [CL-1:0] vld;
        logic          rv;
        logic [DW-1:0] rd;
    } pipe_state_t;

    pipe_state_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        nxt_d.vld[0] = issue_i;
        for (int i = 1; i < CL; i++) begin
            nxt_d.vld[i] = cur_q.vld[i-1];
        end
        nxt_d.rv = cur_q.vld[CL-1];
        if (cur_q.vld[CL-1]) nxt_d.rd = dq_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign rsp_valid_o = cur_q.rv;
    assign rsp_data_o  = cur_q.rd;
endmodule

// File: rtl/dram_rd_sequencer.sv
module dram_rd_sequencer
    import dram_seq_pkg::*;
#(
    parameter int ROW_W         = 13,
    parameter int COL_W         = 10,
    parameter int DATA_W        = 16,
    parameter int T_CL          = 2,
    parameter int T_RCD         = 3,
    parameter int T_RP          = 2,
    parameter int T_RAS         = 8,
    parameter int T_RFC         = 6,
    parameter int CLK_MHZ       = 100,
    parameter int REF_WINDOW_US = 64000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic [COL_W-1:0]  req_col_i,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr_o,
    output logic              dram_ras_no,
    output logic              dram_cas_no,
    output logic              dram_we_no,
    input  logic [DATA_W-1:0] dram_dq_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o
);
    localparam int ADDR_W       = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int REF_INTERVAL = (CLK_MHZ * REF_WINDOW_US) / (2 ** ROW_W);
    localparam int GAP_W        = 8;

    typedef struct packed {
        bank_st_e          st;
        logic [ROW_W-1:0]  row;
        dram_cmd_e         cmd;
        logic [ADDR_W-1:0] addr;
    } seq_state_t;

    seq_state_t       cur_q, nxt_d;
    logic             gap_load, gap_done, ras_load, ras_done;
    logic [GAP_W-1:0] gap_val;
    logic             ref_pend, ref_ack, row_hit;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.cmd   = CMD_NOP;
        nxt_d.addr  = '0;
        gap_load    = 1'b0;
        gap_val     = '0;
        ras_load    = 1'b0;
        ref_ack     = 1'b0;
        row_hit     = (cur_q.row == req_row_i);
        req_ready_o = (cur_q.st == BANK_OPEN) && row_hit && !ref_pend && gap_done;
        unique case (cur_q.st)
            BANK_CLOSED: begin
                if (gap_done) begin
                    if (ref_pend) begin
                        nxt_d.cmd = CMD_REF;
                        gap_load  = 1'b1;
                        gap_val   = GAP_W'(T_RFC - 1);
                        ref_ack   = 1'b1;
                    end else if (req_valid_i) begin
                        nxt_d.cmd  = CMD_ACT;
                        nxt_d.addr = ADDR_W'(req_row_i);
                        nxt_d.row  = req_row_i;
                        nxt_d.st   = BANK_OPEN;
                        gap_load   = 1'b1;
                        gap_val    = GAP_W'(T_RCD - 1);
                        ras_load   = 1'b1;
                    end
                end
            end
            BANK_OPEN: begin
                if (ref_pend || (req_valid_i && !row_hit)) begin
                    if (ras_done) begin
                        nxt_d.cmd = CMD_PRE;
                        nxt_d.st  = BANK_CLOSED;
                        gap_load  = 1'b1;
                        gap_val   = GAP_W'(T_RP - 1);
                    end
                end else if (req_valid_i && req_ready_o) begin
                    nxt_d.cmd  = CMD_RD;
                    nxt_d.addr = ADDR_W'(req_col_i);
                end
            end
            default: nxt_d.st = BANK_CLOSED;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q      <= '0;
            cur_q.st   <= BANK_CLOSED;
            cur_q.cmd  <= CMD_NOP;
        end else begin
            cur_q <= nxt_d;
        end
    end

    seq_gap_timer #(.W(GAP_W)) u_gap_timer (
        .clk_i (clk_i), .rst_ni(rst_ni),
        .load_i(gap_load), .val_i(gap_val), .done_o(gap_done)
    );

    seq_gap_timer #(.W(GAP_W)) u_ras_timer (
        .clk_i (clk_i), .rst_ni(rst_ni),
        .load_i(ras_load), .val_i(GAP_W'(T_RAS - 1)), .done_o(ras_done)
    );

    seq_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ref_ack), .pend_o(ref_pend)
    );

    seq_read_pipe #(.CL(T_CL), .DW(DATA_W)) u_read_pipe (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .issue_i(cur_q.cmd == CMD_RD), .dq_i(dram_dq_i),
        .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o)
    );

    assign dram_ras_no = cur_q.cmd[2];
    assign dram_cas_no = cur_q.cmd[1];
    assign dram_we_no  = cur_q.cmd[0];
    assign dram_addr_o = cur_q.addr;

    // Pin-level spacing counters, kept only for the assertions below
    logic [7:0] since_act_q, since_pre_q, since_ref_q;
    logic       pin_open_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_act_q <= 8'hFF;
            since_pre_q <= 8'hFF;
            since_ref_q <= 8'hFF;
            pin_open_q  <= 1'b0;
        end else begin
            since_act_q <= (cur_q.cmd == CMD_ACT) ? 8'd1 : ((since_act_q == 8'hFF) ? 8'hFF : since_act_q + 8'd1);
            since_pre_q <= (cur_q.cmd == CMD_PRE) ? 8'd1 : ((since_pre_q == 8'hFF) ? 8'hFF : since_pre_q + 8'd1);
            since_ref_q <= (cur_q.cmd == CMD_REF) ? 8'd1 : ((since_ref_q == 8'hFF) ? 8'hFF : since_ref_q + 8'd1);
            if (cur_q.cmd == CMD_ACT)      pin_open_q <= 1'b1;
            else if (cur_q.cmd == CMD_PRE) pin_open_q <= 1'b0;
        end
    end

    assert_rcd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.cmd == CMD_RD) |-> (since_act_q >= 8'(T_RCD)));

    assert_ras_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.cmd == CMD_PRE) |-> (since_act_q >= 8'(T_RAS)));

    assert_rp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.cmd == CMD_ACT || cur_q.cmd == CMD_REF) |-> (since_pre_q >= 8'(T_RP)));

    assert_rfc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.cmd == CMD_ACT) |-> (since_ref_q >= 8'(T_RFC)));

    assert_ref_closed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.cmd == CMD_REF) |-> !pin_open_q);

    assert_handshake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |=>
            (dram_ras_no && !dram_cas_no && dram_we_no && dram_addr_o == ADDR_W'($past(req_col_i))));

    assert_rd_open_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.cmd == CMD_RD) |-> pin_open_q);

    assert_act_closed_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cur_q.cmd == CMD_ACT) |-> !pin_open_q);
endmodule

// File: tb/dram_rd_sequencer_tb_top.sv
`timescale 1ns/1ps
module dram_rd_sequencer_tb_top;
    localparam int ROW_W = 13, COL_W = 10, DATA_W = 16, ADDR_W = 13;
    localparam int T_CL = 2, T_RCD = 3, T_RP = 2, T_RAS = 8, T_RFC = 6;
    localparam int REF_INTERVAL = (100 * 64000) / 8192;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ROW_W-1:0]  req_row = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic [ADDR_W-1:0] dram_addr;
    logic              ras_n, cas_n, we_n;
    logic [DATA_W-1:0] dq_drv = 16'hBAD0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dram_rd_sequencer dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_row_i(req_row), .req_col_i(req_col),
        .dram_addr_o(dram_addr),
        .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n),
        .dram_dq_i(dq_drv),
        .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_data(input logic [31:0] row, input logic [31:0] col);
        return {row[5:0], col[9:0]};
    endfunction

    // Behavioural device model: timing monitor, data source, response scoreboard
    int          cyc = 0;
    int          last_act = -1000, last_pre = -1000, last_ref = -1000;
    int          act_count = 0, pre_count = 0, ref_count = 0, read_count = 0;
    bit          m_open = 1'b0;
    int          m_row = 0;
    int          rd_hist [0:2];
    logic [15:0] dq_pipe [0:T_CL];
    int          exp_cyc [$];
    logic [15:0] exp_dat [$];

    initial begin
        for (int i = 0; i <= T_CL; i++) dq_pipe[i] = 16'hBAD0;
        for (int i = 0; i < 3; i++) rd_hist[i] = -1000;
    end

    always @(negedge clk) begin
        cyc++;
        for (int i = T_CL; i > 0; i--) dq_pipe[i] = dq_pipe[i-1];
        dq_pipe[0] = 16'hBAD0;
        if (rst_n) begin
            case ({ras_n, cas_n, we_n})
                3'b111: ;
                3'b011: begin
                    check(cyc - last_pre >= T_RP, "R6", "act after pre", cyc - last_pre, T_RP);
                    check(cyc - last_ref >= T_RFC, "R9", "act after ref", cyc - last_ref, T_RFC);
                    check(!m_open, "R11", "act while open", m_open, 0);
                    m_open = 1'b1; m_row = int'(dram_addr); last_act = cyc; act_count++;
                end
                3'b101: begin
                    logic [15:0] d;
                    check(m_open, "R11", "read while closed", m_open, 1);
                    check(cyc - last_act >= T_RCD, "R3", "read after act", cyc - last_act, T_RCD);
                    d = mk_data(m_row, dram_addr);
                    dq_pipe[0] = d;
                    exp_cyc.push_back(cyc + T_CL + 1);
                    exp_dat.push_back(d);
                    rd_hist[2] = rd_hist[1]; rd_hist[1] = rd_hist[0]; rd_hist[0] = cyc;
                    read_count++;
                end
                3'b010: begin
                    check(cyc - last_act >= T_RAS, "R5", "pre after act", cyc - last_act, T_RAS);
                    m_open = 1'b0; last_pre = cyc; pre_count++;
                end
                3'b001: begin
                    check(!m_open, "R9", "ref while open", m_open, 0);
                    check(cyc - last_pre >= T_RP, "R6", "ref after pre", cyc - last_pre, T_RP);
                    last_ref = cyc; ref_count++;
                end
                default: check(1'b0, "R2", "illegal strobe code", {ras_n, cas_n, we_n}, 7);
            endcase
        end
        dq_drv = dq_pipe[T_CL];
        if (rsp_valid) begin
            if (exp_cyc.size() == 0) begin
                check(1'b0, "R4", "unexpected response", rsp_data, 0);
            end else begin
                check(cyc == exp_cyc[0], "R4", "response cycle", cyc, exp_cyc[0]);
                check(rsp_data == exp_dat[0], "R4", "response data", rsp_data, exp_dat[0]);
                void'(exp_cyc.pop_front());
                void'(exp_dat.pop_front());
            end
        end else if (exp_cyc.size() != 0 && exp_cyc[0] <= cyc) begin
            check(1'b0, "R4", "missing response", cyc, exp_cyc[0]);
            void'(exp_cyc.pop_front());
            void'(exp_dat.pop_front());
        end
    end

    task automatic wait_ready();
        int guard = 0;
        while (!req_ready && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 2000) check(1'b0, "R10", "ready timeout", 0, 1);
    endtask

    // Holds a request stream on one row, one new column per handshake
    task automatic send(input int row, input int col0, input int n);
        @(negedge clk);
        req_valid = 1'b1;
        req_row   = ROW_W'(row);
        for (int k = 0; k < n; k++) begin
            req_col = COL_W'(col0 + k);
            #1;
            wait_ready();
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check({ras_n, cas_n, we_n} == 3'b111, "R1", "strobes in reset", {ras_n, cas_n, we_n}, 7);
        rst_n = 1'b1;
        @(negedge clk);
        check({ras_n, cas_n, we_n} == 3'b111, "R1", "strobes after reset", {ras_n, cas_n, we_n}, 7);
        check(dram_addr == '0, "R1", "address after reset", dram_addr, 0);
        check(!req_ready && !rsp_valid, "R1", "ready/valid after reset", {req_ready, rsp_valid}, 0);
    endtask

    task automatic t_first_read();
        send(5, 9, 1);
        repeat (T_CL + 3) @(negedge clk);
        check(m_row == 5, "R2", "activated row", m_row, 5);
        check(rd_hist[0] - last_act == T_RCD, "R3", "idle act-to-read gap", rd_hist[0] - last_act, T_RCD);
        check(exp_cyc.size() == 0, "R4", "responses drained", exp_cyc.size(), 0);
    endtask

    task automatic t_row_hit();
        int acts = act_count;
        int reads = read_count;
        send(5, 20, 3);
        repeat (T_CL + 3) @(negedge clk);
        check(act_count == acts, "R7", "no activate on hit", act_count, acts);
        check(read_count == reads + 3, "R7", "read count", read_count, reads + 3);
        check(rd_hist[0] - rd_hist[2] == 2, "R7", "back-to-back reads", rd_hist[0] - rd_hist[2], 2);
    endtask

    task automatic t_row_miss();
        int act_a;
        send(20, 1, 1);
        act_a = last_act;
        send(21, 2, 1);
        repeat (T_CL + 3) @(negedge clk);
        check(last_pre - act_a == T_RAS, "R5", "pre held to tRAS", last_pre - act_a, T_RAS);
        check(last_act - last_pre == T_RP, "R6", "act after tRP", last_act - last_pre, T_RP);
        check(m_row == 21, "R8", "new row opened", m_row, 21);
    endtask

    task automatic t_refresh();
        int refs = ref_count;
        int bad = 0;
        int guard = 0;
        int col = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_row   = ROW_W'(21);
        while (!(ref_count > refs && last_act > last_ref) && guard < 3000) begin
            if (!m_open && req_ready) bad++;
            if (req_ready) col++;
            @(negedge clk);
            req_col = COL_W'(col);
            guard++;
        end
        req_valid = 1'b0;
        repeat (T_CL + 4) @(negedge clk);
        check(ref_count == refs + 1, "R9", "one refresh", ref_count, refs + 1);
        check(last_ref <= 2 * REF_INTERVAL + 50, "R9", "refresh due time", last_ref, 2 * REF_INTERVAL);
        check(bad == 0, "R9", "ready while closed", bad, 0);
        check(last_ref - last_pre == T_RP, "R6", "ref after pre", last_ref - last_pre, T_RP);
        check(last_act - last_ref == T_RFC, "R9", "act after refresh", last_act - last_ref, T_RFC);
        check(exp_cyc.size() == 0, "R4", "responses drained", exp_cyc.size(), 0);
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_first_read();
        t_row_hit();
        t_row_miss();
        t_refresh();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule